// File: doc/BRIEF.md
# Wiper Position Register with One-Hot Tap Decoder

This block keeps the volatile position code of a digitally controlled resistor string and turns it into one-hot switch-select lines for the string's taps. A serial front end delivers write strobes. Each strobe carries a position byte and two flags: one forces the centre position, and one places the resistor in a low-power parked state. The block returns the stored code to the front end for readback, and it drives a control line that disconnects the top end of the string.

While the resistor is parked, the tap selection is forced to the bottom contact and the top end is opened. The stored code is not altered by parking itself. Writes are still accepted while parked. When a write clears the park flag, the selection follows whatever code is stored at that moment. After reset, the position is the centre code and the resistor is not parked.

Top module: `wiper_tap_ctrl`

## Requirements
- R1: After reset, the readback code is the midscale value 0x80 (1 << (CODE_W-1)), only tap_sel bit 128 is high, and top_open is 0.
- R2: A write with wr_mid=0 stores wr_data. From the first clock edge after the strobe, the readback code shows that byte. While not parked, tap_sel has bit D high for code D, where bit 0 is the contact at the bottom terminal.
- R3: A write with wr_mid=1 stores 0x80 and ignores wr_data.
- R4: A write with wr_off=1 parks the resistor from the next clock edge. In that state top_open is 1 and tap_sel equals exactly 1 (bit 0 only), whatever code is stored.
- R5: The parked state lasts until a write with wr_off=0. Clock cycles without a strobe leave it unchanged.
- R6: Writes made while parked still update the stored code. After a write with wr_off=0, top_open is 0 and tap_sel selects the code stored at that time.
- R7: A write with both wr_mid=1 and wr_off=1 stores 0x80 and leaves the outputs parked.
- R8: tap_sel has exactly one bit high in every cycle. The highest code 0xFF selects bit 255, so no bit exists for the top-most string segment.
- R9: The readback code always shows the stored value, including while parked, and never the forced bottom tap.
- R10: Cycles without a strobe change neither the readback code, tap_sel nor top_open, whatever the values on wr_data, wr_mid and wr_off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | One-cycle write strobe from the serial front end |
| wr_data | input | CODE_W | New position code |
| wr_mid | input | 1 | Force midscale; wr_data ignored when 1 |
| wr_off | input | 1 | Park flag: 1 enters, 0 leaves the parked state |
| tap_sel | output | 2**CODE_W | One-hot tap select; bit 0 is the bottom contact |
| top_open | output | 1 | 1 disconnects the top terminal of the string |
| wiper_code | output | CODE_W | Stored position code for readback |

## Verification
The bench builds the block with its default CODE_W of 8, so the full 256-line select vector is compared as a whole against an expected vector computed in the bench. With that width, every code from 0x00 to 0xFF can be swept. This includes both ends of the string and the midscale value that reset and the midscale flag share. Writes are also made with the park flag set, together with the midscale flag, and with garbage data on the inputs during idle cycles.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    // Default width of the position code
    localparam int WP_CODE_W_DEF = 8;

    // Midscale code for a given width: only the top bit set
    function automatic int unsigned wp_mid(input int unsigned w);
        return 32'd1 << (w - 1);
    endfunction

endpackage

// File: rtl/wiper_store.sv
module wiper_store #(
    parameter int CODE_W = wiper_pkg::WP_CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              wr_mid,
    input  logic              wr_off,
    output logic [CODE_W-1:0] code_q_o,
    output logic              park_q_o,
    output logic [CODE_W-1:0] code_nx_o,
    output logic              park_nx_o
);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(wiper_pkg::wp_mid(CODE_W));

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              park;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stb) begin
            st_d.code = wr_mid ? MID_CODE : wr_data;
            st_d.park = wr_off;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= MID_CODE;
            st_q.park <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_q_o  = st_q.code;
    assign park_q_o  = st_q.park;
    assign code_nx_o = st_d.code;
    assign park_nx_o = st_d.park;

    AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_mid) |=> (st_q.code == $past(wr_data)));          // R2
    AST_MID_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_mid) |=> (st_q.code == MID_CODE));                  // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ($stable(st_q.code) && $stable(st_q.park)));         // R10

endmodule

// File: rtl/tap_onehot_dec.sv
module tap_onehot_dec #(
    parameter int CODE_W = wiper_pkg::WP_CODE_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CODE_W-1:0]     code_nx,
    input  logic                  park_nx,
    output logic [(1<<CODE_W)-1:0] tap_q_o
);
    localparam int NUM_TAPS = 1 << CODE_W;
    localparam int MID_IDX  = NUM_TAPS / 2;

    logic [NUM_TAPS-1:0] tap_d, tap_q;

    // Each line compares against its own index; parking forces line 0
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_line
        localparam logic IS_BOTTOM = (i == 0);
        always_comb begin
            tap_d[i] = park_nx ? IS_BOTTOM : (code_nx == CODE_W'(i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q <= NUM_TAPS'(1) << MID_IDX;
        end else begin
            tap_q <= tap_d;
        end
    end

    assign tap_q_o = tap_q;

    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(tap_q));                                                  // R8

endmodule

// File: rtl/wiper_tap_ctrl.sv
module wiper_tap_ctrl #(
    parameter int CODE_W = wiper_pkg::WP_CODE_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_stb,
    input  logic [CODE_W-1:0]       wr_data,
    input  logic                    wr_mid,
    input  logic                    wr_off,
    output logic [(1<<CODE_W)-1:0]  tap_sel,
    output logic                    top_open,
    output logic [CODE_W-1:0]       wiper_code
);
    localparam int NUM_TAPS = 1 << CODE_W;

    logic [CODE_W-1:0] code_q, code_nx;
    logic              park_q, park_nx;

    wiper_store #(.CODE_W(CODE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .wr_mid   (wr_mid),
        .wr_off   (wr_off),
        .code_q_o (code_q),
        .park_q_o (park_q),
        .code_nx_o(code_nx),
        .park_nx_o(park_nx)
    );

    tap_onehot_dec #(.CODE_W(CODE_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .code_nx(code_nx),
        .park_nx(park_nx),
        .tap_q_o(tap_sel)
    );

    assign top_open   = park_q;
    assign wiper_code = code_q;

    AST_PARK_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        top_open |-> (tap_sel == NUM_TAPS'(1)));                          // R4
    AST_PARK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (top_open == $past(wr_off)));                          // R5
    AST_RUN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !top_open |-> tap_sel[wiper_code]);                               // R6

endmodule

// File: tb/sim_wiper_tap_ctrl.sv
module sim_wiper_tap_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int NT = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [CW-1:0] wr_data = '0;
    logic          wr_mid = 1'b0;
    logic          wr_off = 1'b0;
    logic [NT-1:0] tap_sel;
    logic          top_open;
    logic [CW-1:0] wiper_code;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_tap_ctrl #(.CODE_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .wr_mid(wr_mid), .wr_off(wr_off), .tap_sel(tap_sel),
        .top_open(top_open), .wiper_code(wiper_code)
    );

    task automatic expect_out(input logic [CW-1:0] ecode, input logic epark, input string req);
        logic [NT-1:0] etap;
        etap = epark ? NT'(1) : (NT'(1) << ecode);
        total++;
        if (wiper_code !== ecode) begin
            bad++;
            $display("FAIL %s readback actual=%0h expected=%0h", req, wiper_code, ecode);
        end
        total++;
        if (top_open !== epark) begin
            bad++;
            $display("FAIL %s top_open actual=%0b expected=%0b", req, top_open, epark);
        end
        total++;
        if (tap_sel !== etap) begin
            bad++;
            $display("FAIL %s tap_sel actual=%0h expected=%0h", req, tap_sel, etap);
        end
    endtask

    // Strobe for one cycle; outputs are valid at the following falling edge
    task automatic do_write(input logic [CW-1:0] d, input logic mid, input logic off);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = d; wr_mid = mid; wr_off = off;
        @(negedge clk);
        wr_stb = 1'b0; wr_data = ~d; wr_mid = ~mid; wr_off = ~off;
    endtask

    task automatic t_reset;
        @(negedge clk);
        expect_out(8'h80, 1'b0, "R1");
    endtask

    task automatic t_sweep;
        for (int c = 0; c < NT; c++) begin
            do_write(CW'(c), 1'b0, 1'b0);
            expect_out(CW'(c), 1'b0, (c == NT-1) ? "R8" : "R2");
        end
    endtask

    task automatic t_mid;
        do_write(8'h13, 1'b0, 1'b0);
        do_write(8'hE7, 1'b1, 1'b0);
        expect_out(8'h80, 1'b0, "R3");
    endtask

    task automatic t_park;
        do_write(8'h5A, 1'b0, 1'b0);
        expect_out(8'h5A, 1'b0, "R2");
        do_write(8'h5A, 1'b0, 1'b1);
        expect_out(8'h5A, 1'b1, "R4");
        expect_out(8'h5A, 1'b1, "R9");
        repeat (5) @(negedge clk);
        expect_out(8'h5A, 1'b1, "R5");
    endtask

    task automatic t_write_parked;
        do_write(8'h33, 1'b0, 1'b1);
        expect_out(8'h33, 1'b1, "R6");
        do_write(8'h33, 1'b0, 1'b0);
        expect_out(8'h33, 1'b0, "R6");
    endtask

    task automatic t_both;
        do_write(8'h01, 1'b0, 1'b0);
        do_write(8'hFE, 1'b1, 1'b1);
        expect_out(8'h80, 1'b1, "R7");
        do_write(8'h00, 1'b1, 1'b0);
        expect_out(8'h80, 1'b0, "R7");
    endtask

    task automatic t_idle;
        do_write(8'hC4, 1'b0, 1'b0);
        @(negedge clk);
        wr_data = 8'h11; wr_mid = 1'b1; wr_off = 1'b1;
        repeat (4) @(negedge clk);
        expect_out(8'hC4, 1'b0, "R10");
        do_write(8'h00, 1'b0, 1'b0);
        expect_out(8'h00, 1'b0, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sweep();
        t_mid();
        t_park();
        t_write_parked();
        t_both();
        t_idle();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule